// File: doc/BRIEF.md
# Set-Dueling Policy Selector

This block decides which of two cache replacement policies the bulk of a cache should follow. A fixed group of 32 cache sets acts as a test ground. Two shadow directories, one per candidate policy, watch the accesses to these sets. Each shadow directory holds 16-bit partial tags and reports a miss when no partial tag matches. The block compares the two miss reports on every valid access to a sampled set. It keeps a saturating score of which policy is losing more often.

The score is a 10-bit counter that starts at its midpoint. A miss seen only by policy 0 moves the score up. A miss seen only by policy 1 moves it down. When both policies agree, the score holds. The top bit of the score is the selection that all non-sampled (follower) sets use. The block also tells the shadow directories, combinationally, whether the set now being presented is one of the sampled sets.

Sampling is static. A set index is sampled when its lowest five bits equal its highest five bits and every bit between those two fields is zero. This gives exactly 32 sampled sets for any index width of ten bits or more.

Top module: `set_duel_selector`

## Requirements
- R1: While reset is held and on the first cycle after its release, `duel_cnt` equals the midpoint 2^(CNT_W-1) (512 by default) and `follow_p1` is 1.
- R2: `set_sampled` is 1 exactly when `acc_set[4:0]` equals `acc_set[IDX_W-1:IDX_W-5]` and all bits of `acc_set` between those two fields are 0. It depends only on `acc_set`, not on `acc_valid`.
- R3: Over the full range of set indices, exactly 32 indices drive `set_sampled` high.
- R4: A valid access to a sampled set with `p0_miss`=1 and `p1_miss`=0 raises `duel_cnt` by one on the next clock edge, unless it is already at its maximum.
- R5: A valid access to a sampled set with `p0_miss`=0 and `p1_miss`=1 lowers `duel_cnt` by one on the next clock edge, unless it is already 0.
- R6: When `p0_miss` equals `p1_miss`, `duel_cnt` keeps its value.
- R7: When `acc_valid` is 0, or the set is not sampled, `duel_cnt` keeps its value whatever the miss inputs are.
- R8: At the maximum value 2^CNT_W-1 (1023), further policy-0-only misses leave `duel_cnt` unchanged.
- R9: At 0, further policy-1-only misses leave `duel_cnt` unchanged.
- R10: `follow_p1` always equals the most significant bit of `duel_cnt`. A value of 1 selects policy 1 for the follower sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | IDX_W | Set index of the access |
| p0_miss | input | 1 | Shadow directory of policy 0 missed |
| p1_miss | input | 1 | Shadow directory of policy 1 missed |
| set_sampled | output | 1 | The presented set is a sampled set |
| follow_p1 | output | 1 | Follower sets use policy 1 when 1 |
| duel_cnt | output | CNT_W | Current selector score |

## Verification
The hardest states to reach are the two saturation edges. Each one lies 511 or 512 disagreeing sampled accesses away from the reset midpoint. The stimulus drives long, unbroken runs of policy-0-only misses and then policy-1-only misses, spread across all 32 sampled sets. It keeps going past both limits, so that the counter sits at 1023 and then at 0 while more disagreements arrive. A full sweep of every index counts the sampled sets. Disagreeing misses on non-sampled sets, and on cycles where the access is not valid, are mixed in to show that they leave the score unchanged.

// File: rtl/sdps_pkg.sv
package sdps_pkg;

    // Default geometry of the selector
    localparam int SDPS_IDX_W   = 10;
    localparam int SDPS_FIELD_W = 5;
    localparam int SDPS_CNT_W   = 10;

    // Outcome of one access, as seen by the score counter
    typedef enum logic [1:0] {
        VOTE_NONE = 2'd0,
        VOTE_UP   = 2'd1,
        VOTE_DN   = 2'd2
    } vote_e;

endpackage

// File: rtl/sdps_sample_decode.sv
module sdps_sample_decode #(
    parameter int IDX_W   = sdps_pkg::SDPS_IDX_W,
    parameter int FIELD_W = sdps_pkg::SDPS_FIELD_W
) (
    input  logic [IDX_W-1:0] set_i,
    output logic             sampled_o
);
    localparam int MID_W = IDX_W - 2 * FIELD_W;

    logic [FIELD_W-1:0] low_f;
    logic [FIELD_W-1:0] high_f;
    logic               mid_zero;

    assign low_f  = set_i[FIELD_W-1:0];
    assign high_f = set_i[IDX_W-1 -: FIELD_W];

    generate
        if (MID_W > 0) begin : g_mid
            assign mid_zero = (set_i[IDX_W-FIELD_W-1:FIELD_W] == '0);
        end else begin : g_nomid
            assign mid_zero = 1'b1;
        end
    endgenerate

    // R2: fixed sampling rule
    assign sampled_o = mid_zero && (low_f == high_f);

endmodule

// File: rtl/sdps_vote.sv
module sdps_vote
    import sdps_pkg::*;
(
    input  logic  valid_i,
    input  logic  sampled_i,
    input  logic  p0_miss_i,
    input  logic  p1_miss_i,
    output vote_e vote_o
);
    always_comb begin
        vote_o = VOTE_NONE;
        if (valid_i && sampled_i) begin
            if (p0_miss_i && !p1_miss_i) begin
                vote_o = VOTE_UP;
            end else if (!p0_miss_i && p1_miss_i) begin
                vote_o = VOTE_DN;
            end
        end
    end

endmodule

// File: rtl/sdps_sat_counter.sv
module sdps_sat_counter
    import sdps_pkg::*;
#(
    parameter int CNT_W = SDPS_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vote_e            vote_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (vote_i)
            VOTE_UP: if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            VOTE_DN: if (s_q.cnt != '0)      s_d.cnt = s_q.cnt - 1'b1;
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= CNT_MID;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_i == VOTE_UP && s_q.cnt != CNT_MAX) |=> s_q.cnt == $past(s_q.cnt) + 1'b1);

    assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_i == VOTE_DN && s_q.cnt != '0) |=> s_q.cnt == $past(s_q.cnt) - 1'b1);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_i == VOTE_NONE) |=> $stable(s_q.cnt));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && vote_i != VOTE_DN) |=> s_q.cnt == CNT_MAX);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0 && vote_i != VOTE_UP) |=> s_q.cnt == '0);

endmodule

// File: rtl/set_duel_selector.sv
module set_duel_selector
    import sdps_pkg::*;
#(
    parameter int IDX_W   = SDPS_IDX_W,
    parameter int FIELD_W = SDPS_FIELD_W,
    parameter int CNT_W   = SDPS_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_set,
    input  logic             p0_miss,
    input  logic             p1_miss,
    output logic             set_sampled,
    output logic             follow_p1,
    output logic [CNT_W-1:0] duel_cnt
);
    vote_e vote;

    sdps_sample_decode #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_dec (
        .set_i     (acc_set),
        .sampled_o (set_sampled)
    );

    sdps_vote u_vote (
        .valid_i   (acc_valid),
        .sampled_i (set_sampled),
        .p0_miss_i (p0_miss),
        .p1_miss_i (p1_miss),
        .vote_o    (vote)
    );

    sdps_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .vote_i(vote),
        .cnt_o (duel_cnt)
    );

    // R10: follower sets take the score's top bit
    assign follow_p1 = duel_cnt[CNT_W-1];

    assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vote != VOTE_NONE) |-> (acc_valid && set_sampled));

    assert_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_miss == p1_miss) |-> (vote == VOTE_NONE));

endmodule

// File: tb/sim_set_duel_selector.sv
module sim_set_duel_selector;
    localparam int IDX_W = 10;
    localparam int CNT_W = 10;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_set = '0;
    logic             p0_miss = 1'b0;
    logic             p1_miss = 1'b0;
    logic             set_sampled;
    logic             follow_p1;
    logic [CNT_W-1:0] duel_cnt;

    int errors = 0;
    int checks = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    set_duel_selector #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .p0_miss(p0_miss), .p1_miss(p1_miss), .set_sampled(set_sampled),
        .follow_p1(follow_p1), .duel_cnt(duel_cnt)
    );

    function automatic bit ref_sampled(int s);
        int lo, hi, mid;
        lo  = s % 32;
        hi  = s / (1 << (IDX_W - 5));
        mid = (s / 32) % (1 << (IDX_W - 10));
        return (lo == hi) && (mid == 0);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, register at posedge, compare at next negedge
    task automatic step(bit v, int s, bit m0, bit m1, string req);
        acc_valid = v; acc_set = s[IDX_W-1:0]; p0_miss = m0; p1_miss = m1;
        #1;
        chk(set_sampled == ref_sampled(s), "R2", set_sampled, ref_sampled(s));
        @(posedge clk);
        if (v && ref_sampled(s) && m0 && !m1 && model < CMAX) model++;
        else if (v && ref_sampled(s) && !m0 && m1 && model > 0) model--;
        @(negedge clk);
        chk(duel_cnt == model, req, duel_cnt, model);
        chk(follow_p1 == (model >= (CMAX + 1) / 2), "R10", follow_p1, model >= (CMAX + 1) / 2);
    endtask

    function automatic int samp(int k);
        return ((k % 32) << 5) | (k % 32);
    endfunction

    initial begin
        int nsamp;
        repeat (3) @(negedge clk);
        chk(duel_cnt == 512, "R1", duel_cnt, 512);
        chk(follow_p1 == 1'b1, "R1", follow_p1, 1);
        rst_n = 1'b1;
        model = 512;
        @(negedge clk);
        chk(duel_cnt == 512, "R1", duel_cnt, 512);

        // R3: sweep every index with the access not valid (R7 hold)
        nsamp = 0;
        for (int s = 0; s < (1 << IDX_W); s++) begin
            acc_valid = 1'b0; acc_set = s[IDX_W-1:0]; p0_miss = s[0]; p1_miss = ~s[0];
            #1;
            if (set_sampled) nsamp++;
            chk(set_sampled == ref_sampled(s), "R2", set_sampled, ref_sampled(s));
            @(negedge clk);
        end
        chk(nsamp == 32, "R3", nsamp, 32);
        chk(duel_cnt == 512, "R7", duel_cnt, 512);

        // mixed pattern
        for (int i = 0; i < 200; i++) begin
            int s;
            s = ((i * 7) % 3 == 0) ? samp(i * 5) : (i * 37 + 3) % 1024;
            step((i % 5) != 0, s, (i % 3) == 0, (i % 4) == 0, "R4/R5/R6/R7");
        end
        // agreement and invalid/non-sampled disagreement
        for (int i = 0; i < 32; i++) begin
            step(1, samp(i), 1, 1, "R6");
            step(1, samp(i), 0, 0, "R6");
            step(0, samp(i), 1, 0, "R7");
            step(1, samp(i) ^ 32'h40, 0, 1, "R7");
        end
        // drive to the top and past it
        for (int i = 0; i < 560; i++) step(1, samp(i), 1, 0, "R4");
        chk(duel_cnt == CMAX, "R8", duel_cnt, CMAX);
        for (int i = 0; i < 8; i++) step(1, samp(i), 1, 0, "R8");
        // drive to the bottom and past it
        for (int i = 0; i < 1040; i++) step(1, samp(i + 3), 0, 1, "R5");
        chk(duel_cnt == 0, "R9", duel_cnt, 0);
        chk(follow_p1 == 1'b0, "R10", follow_p1, 0);
        for (int i = 0; i < 8; i++) step(1, samp(i), 0, 1, "R9");
        for (int i = 0; i < 4; i++) step(1, samp(i), 1, 0, "R4");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule